// File: doc/BRIEF.md
# Multi-Mode Task File Address Decoder

This block sits between the host bus pins of a removable storage card and its ATA task-file register bank. On every clock it looks at the eleven host address lines, the two card enables, the memory and I/O strobe pairs and the attribute/common select. From these it works out which single task-file register the host is touching, and whether the access is a read or a write. The decode follows one of five address maps, chosen by a three-bit mode code that the configuration logic elsewhere supplies: a 2 KB common-memory window, the primary or secondary legacy I/O ranges, a 16-byte contiguous I/O block, or the IDE-style map that uses the card enables as chip selects.

The result is registered once. It appears as a one-hot register select, read and write qualifiers, and a flag that marks accesses falling into the sequential data window in the upper half of the memory map. Downstream logic uses that flag to treat those accesses as FIFO pops or pushes rather than random reads. Status and command share an address, as do error and feature and also alternate status and device control; the block resolves each of these pairs by transfer direction so that downstream logic never needs to look at the strobes again.

Top module: `tf_addr_decoder`

## Requirements
- R1: A synchronous active-high reset clears the select, both qualifiers and the window flag on the next rising edge, whatever the inputs are doing.
- R2: The outputs reflect the inputs sampled at the previous rising edge (one register stage). The select is one-hot or zero and is non-zero exactly when a qualifier is set. Select bit positions: 0 data, 1 error, 2 feature, 3 sector count, 4 sector number, 5 cylinder low, 6 cylinder high, 7 drive/head, 8 status, 9 command, 10 alternate status, 11 device control, 12 drive address, 13 duplicate even data, 14 duplicate odd data.
- R3: Mode code 0 (memory window) needs the attribute/common select high and at least one card enable low. Offsets 0h–Fh then decode as the low-offset table: 0 data, 1 error/feature, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head, 7 status/command, 8 duplicate even data, 9 duplicate odd data, Dh error/feature, Eh alternate status/device control, Fh drive address; Ah–Ch select nothing. An access with the attribute select low is ignored.
- R4: In mode 0, any offset with A10 set selects the data register and raises the window flag. Offsets 10h–3FFh select nothing.
- R5: Mode code 1 (primary I/O) decodes A9–A0. 1F0h–1F7h select low-table offsets 0–7, and 3F6h/3F7h select alternate status/device control and drive address. A10 has no effect, and other addresses select nothing.
- R6: Mode code 2 (secondary I/O) is the same as R5 with 170h–177h and 376h–377h.
- R7: Mode code 3 (contiguous I/O) decodes only A3–A0 through the low-offset table of R3. A card enable must be low, and higher address bits have no effect.
- R8: Mode code 4 (IDE) decodes A2–A0. With only card enable 1 low, offsets 0–7 follow the low table. With only card enable 2 low, offset 6 is alternate status/device control and offset 7 is drive address, and other offsets select nothing. With both enables low or both high, nothing is selected.
- R9: On a shared address a read selects status, error or alternate status, and a write selects command, feature or device control respectively.
- R10: Mode 0 qualifies with the output/write enables. Modes 1–4 qualify with the I/O read/write strobes, and the other strobe pair is ignored. An access counts only when exactly one strobe of the relevant pair is active.
- R11: Mode codes 5–7 select nothing. In modes 0–3 an access with both card enables high selects nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | Address map code (0 memory window, 1 primary, 2 secondary, 3 contiguous, 4 IDE) |
| addr_i | input | 11 | Host address A10–A0 |
| ce1_n_i | input | 1 | Card enable 1, active low |
| ce2_n_i | input | 1 | Card enable 2, active low |
| oe_n_i | input | 1 | Memory output enable, active low |
| we_n_i | input | 1 | Memory write enable, active low |
| iord_n_i | input | 1 | I/O read strobe, active low |
| iowr_n_i | input | 1 | I/O write strobe, active low |
| attr_n_i | input | 1 | Low selects attribute space, high selects common space |
| sel_o | output | 15 | One-hot task-file register select |
| rd_o | output | 1 | Registered read qualifier |
| wr_o | output | 1 | Registered write qualifier |
| fifo_o | output | 1 | Access lies in the sequential data window |

## Verification
The checker watches, on every cycle, the invariants that tie the outputs to one another and to the inputs of the previous cycle. These are: the select is one-hot and agrees with the qualifiers, read and write never coincide, reset clears everything, a read traces back to the strobe that belongs to the current mode, and the window flag only accompanies a data select from a memory-mode access with A10 set. They also cover the cases that must select nothing: attribute-space accesses, bad mode codes, and IDE accesses with both or neither card enable active. Only the bench's scenarios can show that each address of each map lands on the right register, that aliased upper address bits really are ignored, and that shared addresses split correctly by direction.

// File: rtl/tfd_pkg.sv
package tfd_pkg;

    localparam int TF_REGS   = 15;
    localparam int MAP_COUNT = 5;

    typedef enum logic [3:0] {
        TF_DATA     = 4'd0,
        TF_ERROR    = 4'd1,
        TF_FEATURE  = 4'd2,
        TF_SECCNT   = 4'd3,
        TF_SECNUM   = 4'd4,
        TF_CYLLO    = 4'd5,
        TF_CYLHI    = 4'd6,
        TF_DRVHD    = 4'd7,
        TF_STATUS   = 4'd8,
        TF_COMMAND  = 4'd9,
        TF_ALTSTAT  = 4'd10,
        TF_DEVCTL   = 4'd11,
        TF_DRVADDR  = 4'd12,
        TF_DUPEVEN  = 4'd13,
        TF_DUPODD   = 4'd14
    } tf_reg_e;

    typedef enum logic [2:0] {
        MAP_MEMWIN    = 3'd0,
        MAP_PRIMARY   = 3'd1,
        MAP_SECONDARY = 3'd2,
        MAP_CONTIG    = 3'd3,
        MAP_IDE       = 3'd4
    } map_mode_e;

    // Result of one address map: which register on read, which on write.
    typedef struct packed {
        logic    hit;
        tf_reg_e rd_reg;
        tf_reg_e wr_reg;
        logic    fifo;
    } tf_hit_t;

    localparam tf_hit_t NO_HIT = '{hit: 1'b0, rd_reg: TF_DATA, wr_reg: TF_DATA, fifo: 1'b0};

    // Shared 16-offset layout used by every map for its register block.
    function automatic tf_hit_t low_map(input logic [3:0] off);
        tf_hit_t h;
        h = '{hit: 1'b1, rd_reg: TF_DATA, wr_reg: TF_DATA, fifo: 1'b0};
        case (off)
            4'h0: ;
            4'h1, 4'hD: begin h.rd_reg = TF_ERROR;   h.wr_reg = TF_FEATURE; end
            4'h2: begin h.rd_reg = TF_SECCNT;  h.wr_reg = TF_SECCNT;  end
            4'h3: begin h.rd_reg = TF_SECNUM;  h.wr_reg = TF_SECNUM;  end
            4'h4: begin h.rd_reg = TF_CYLLO;   h.wr_reg = TF_CYLLO;   end
            4'h5: begin h.rd_reg = TF_CYLHI;   h.wr_reg = TF_CYLHI;   end
            4'h6: begin h.rd_reg = TF_DRVHD;   h.wr_reg = TF_DRVHD;   end
            4'h7: begin h.rd_reg = TF_STATUS;  h.wr_reg = TF_COMMAND; end
            4'h8: begin h.rd_reg = TF_DUPEVEN; h.wr_reg = TF_DUPEVEN; end
            4'h9: begin h.rd_reg = TF_DUPODD;  h.wr_reg = TF_DUPODD;  end
            4'hE: begin h.rd_reg = TF_ALTSTAT; h.wr_reg = TF_DEVCTL;  end
            4'hF: begin h.rd_reg = TF_DRVADDR; h.wr_reg = TF_DRVADDR; end
            default: h = NO_HIT;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/tf_addr_match.sv
module tf_addr_match
    import tfd_pkg::*;
#(
    parameter int          ADDR_W   = 11,
    parameter int          MODE_W   = 3,
    parameter int          MODES    = MAP_COUNT,
    parameter logic [9:0]  PRI_BASE = 10'h1F0,
    parameter logic [9:0]  PRI_CTRL = 10'h3F6,
    parameter logic [9:0]  SEC_BASE = 10'h170,
    parameter logic [9:0]  SEC_CTRL = 10'h376
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce1_n_i,
    input  logic              ce2_n_i,
    input  logic              attr_n_i,
    output tf_hit_t           res_o
);

    localparam int IO_W   = ADDR_W - 1;   // I/O maps ignore the top address line
    localparam int WIN_B  = ADDR_W - 1;   // memory-map bit that opens the data window
    localparam int BLK_W  = 4;            // register block spans 16 offsets

    function automatic tf_hit_t io_range(input logic [IO_W-1:0] a,
                                         input logic [9:0] base,
                                         input logic [9:0] ctrl);
        tf_hit_t h;
        h = NO_HIT;
        if (a[IO_W-1:3] == base[IO_W-1:3])
            h = low_map({1'b0, a[2:0]});
        else if (a[IO_W-1:1] == ctrl[IO_W-1:1])
            h = low_map({3'b111, a[0]});
        return h;
    endfunction

    function automatic tf_hit_t decode_one(input int m,
                                           input logic [ADDR_W-1:0] a,
                                           input logic c1n,
                                           input logic c2n,
                                           input logic atn);
        tf_hit_t h;
        logic    card_en;
        card_en = !(c1n && c2n);
        h = NO_HIT;
        case (m)
            int'(MAP_MEMWIN): begin
                if (card_en && atn) begin
                    if (a[WIN_B])
                        h = '{hit: 1'b1, rd_reg: TF_DATA, wr_reg: TF_DATA, fifo: 1'b1};
                    else if (a[WIN_B-1:BLK_W] == '0)
                        h = low_map(a[BLK_W-1:0]);
                end
            end
            int'(MAP_PRIMARY):   if (card_en) h = io_range(a[IO_W-1:0], PRI_BASE, PRI_CTRL);
            int'(MAP_SECONDARY): if (card_en) h = io_range(a[IO_W-1:0], SEC_BASE, SEC_CTRL);
            int'(MAP_CONTIG):    if (card_en) h = low_map(a[BLK_W-1:0]);
            int'(MAP_IDE): begin
                if (!c1n && c2n)
                    h = low_map({1'b0, a[2:0]});
                else if (c1n && !c2n && a[2:1] == 2'b11)
                    h = low_map({3'b111, a[0]});
            end
            default: h = NO_HIT;
        endcase
        return h;
    endfunction

    tf_hit_t          res_arr [MODES];
    logic [MODES-1:0] hits;

    for (genvar g = 0; g < MODES; g++) begin : g_map
        always_comb begin
            if (mode_i == MODE_W'(g))
                res_arr[g] = decode_one(g, addr_i, ce1_n_i, ce2_n_i, attr_n_i);
            else
                res_arr[g] = NO_HIT;
            hits[g] = res_arr[g].hit;
        end
    end

    logic single;
    assign single = (hits != '0) && ((hits & (hits - MODES'(1))) == '0);

    always_comb begin
        res_o = NO_HIT;
        for (int k = 0; k < MODES; k++)
            if (single && hits[k]) res_o = res_arr[k];
    end

endmodule

// File: rtl/tf_strobe_qual.sv
module tf_strobe_qual
    import tfd_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int MODES  = MAP_COUNT
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic              iord_n_i,
    input  logic              iowr_n_i,
    output logic              rd_o,
    output logic              wr_o
);

    logic r_raw, w_raw;

    always_comb begin
        if (mode_i == MODE_W'(MAP_MEMWIN)) begin
            r_raw = !oe_n_i;
            w_raw = !we_n_i;
        end else if (mode_i < MODE_W'(MODES)) begin
            r_raw = !iord_n_i;
            w_raw = !iowr_n_i;
        end else begin
            r_raw = 1'b0;
            w_raw = 1'b0;
        end
    end

    assign rd_o = r_raw && !w_raw;
    assign wr_o = w_raw && !r_raw;

endmodule

// File: rtl/tf_sel_reg.sv
module tf_sel_reg
    import tfd_pkg::*;
#(
    parameter int NREG = TF_REGS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_i,
    input  logic            wr_i,
    input  tf_reg_e         idx_i,
    input  logic            fifo_i,
    output logic [NREG-1:0] sel_o,
    output logic            rd_o,
    output logic            wr_o,
    output logic            fifo_o
);

    logic [NREG-1:0] sel_nxt;

    for (genvar r = 0; r < NREG; r++) begin : g_onehot
        assign sel_nxt[r] = (rd_i || wr_i) && (idx_i == tf_reg_e'(r));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_o  <= '0;
            rd_o   <= 1'b0;
            wr_o   <= 1'b0;
            fifo_o <= 1'b0;
        end else begin
            sel_o  <= sel_nxt;
            rd_o   <= rd_i;
            wr_o   <= wr_i;
            fifo_o <= fifo_i && (rd_i || wr_i);
        end
    end

endmodule

// File: rtl/tf_addr_decoder.sv
module tf_addr_decoder
    import tfd_pkg::*;
#(
    parameter int         ADDR_W   = 11,
    parameter int         MODE_W   = 3,
    parameter logic [9:0] PRI_BASE = 10'h1F0,
    parameter logic [9:0] PRI_CTRL = 10'h3F6,
    parameter logic [9:0] SEC_BASE = 10'h170,
    parameter logic [9:0] SEC_CTRL = 10'h376
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               ce1_n_i,
    input  logic               ce2_n_i,
    input  logic               oe_n_i,
    input  logic               we_n_i,
    input  logic               iord_n_i,
    input  logic               iowr_n_i,
    input  logic               attr_n_i,
    output logic [TF_REGS-1:0] sel_o,
    output logic               rd_o,
    output logic               wr_o,
    output logic               fifo_o
);

    tf_hit_t match;
    logic    strb_rd, strb_wr;
    logic    acc_rd, acc_wr;
    tf_reg_e acc_idx;

    tf_addr_match #(
        .ADDR_W  (ADDR_W),
        .MODE_W  (MODE_W),
        .MODES   (MAP_COUNT),
        .PRI_BASE(PRI_BASE),
        .PRI_CTRL(PRI_CTRL),
        .SEC_BASE(SEC_BASE),
        .SEC_CTRL(SEC_CTRL)
    ) u_match (
        .mode_i  (mode_i),
        .addr_i  (addr_i),
        .ce1_n_i (ce1_n_i),
        .ce2_n_i (ce2_n_i),
        .attr_n_i(attr_n_i),
        .res_o   (match)
    );

    tf_strobe_qual #(
        .MODE_W(MODE_W),
        .MODES (MAP_COUNT)
    ) u_qual (
        .mode_i  (mode_i),
        .oe_n_i  (oe_n_i),
        .we_n_i  (we_n_i),
        .iord_n_i(iord_n_i),
        .iowr_n_i(iowr_n_i),
        .rd_o    (strb_rd),
        .wr_o    (strb_wr)
    );

    assign acc_rd  = match.hit && strb_rd;
    assign acc_wr  = match.hit && strb_wr;
    assign acc_idx = strb_rd ? match.rd_reg : match.wr_reg;

    tf_sel_reg #(
        .NREG(TF_REGS)
    ) u_out (
        .clk   (clk),
        .rst   (rst),
        .rd_i  (acc_rd),
        .wr_i  (acc_wr),
        .idx_i (acc_idx),
        .fifo_i(match.fifo),
        .sel_o (sel_o),
        .rd_o  (rd_o),
        .wr_o  (wr_o),
        .fifo_o(fifo_o)
    );

endmodule

// File: rtl/tf_addr_decoder_checks.sv
module tf_addr_decoder_checks
    import tfd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int MODE_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [MODE_W-1:0]  mode_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic               ce1_n_i,
    input logic               ce2_n_i,
    input logic               oe_n_i,
    input logic               we_n_i,
    input logic               iord_n_i,
    input logic               iowr_n_i,
    input logic               attr_n_i,
    input logic [TF_REGS-1:0] sel_o,
    input logic               rd_o,
    input logic               wr_o,
    input logic               fifo_o
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_o == '0 && !rd_o && !wr_o && !fifo_o));

    p_onehot_sel_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o) && ((sel_o != '0) == (rd_o || wr_o)));

    p_no_rd_wr_r10: assert property (@(posedge clk) disable iff (rst)
        !(rd_o && wr_o));

    p_rd_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        rd_o |-> $past(mode_i == MODE_W'(MAP_MEMWIN) ? !oe_n_i : !iord_n_i));

    p_wr_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        wr_o |-> $past(mode_i == MODE_W'(MAP_MEMWIN) ? !we_n_i : !iowr_n_i));

    p_fifo_window_r4: assert property (@(posedge clk) disable iff (rst)
        fifo_o |-> (sel_o[TF_DATA] && $past(mode_i) == MODE_W'(MAP_MEMWIN)
                    && $past(addr_i[ADDR_W-1])));

    p_status_read_r9: assert property (@(posedge clk) disable iff (rst)
        (sel_o[TF_STATUS] || sel_o[TF_ERROR] || sel_o[TF_ALTSTAT]) |-> rd_o);

    p_command_write_r9: assert property (@(posedge clk) disable iff (rst)
        (sel_o[TF_COMMAND] || sel_o[TF_FEATURE] || sel_o[TF_DEVCTL]) |-> wr_o);

    p_attr_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        $past(mode_i == MODE_W'(MAP_MEMWIN) && !attr_n_i) |-> sel_o == '0);

    p_ide_enables_r8: assert property (@(posedge clk) disable iff (rst)
        $past(mode_i == MODE_W'(MAP_IDE) && ce1_n_i == ce2_n_i) |-> sel_o == '0);

    p_bad_mode_r11: assert property (@(posedge clk) disable iff (rst)
        $past(mode_i > MODE_W'(MAP_IDE)) |-> sel_o == '0);

endmodule

bind tf_addr_decoder tf_addr_decoder_checks #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_checks (.*);

// File: tb/tf_addr_decoder_test.sv
module tf_addr_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_i = 3'd0;
    logic [10:0] addr_i = '0;
    logic        ce1_n_i = 1'b1, ce2_n_i = 1'b1;
    logic        oe_n_i = 1'b1, we_n_i = 1'b1;
    logic        iord_n_i = 1'b1, iowr_n_i = 1'b1;
    logic        attr_n_i = 1'b1;
    logic [14:0] sel_o;
    logic        rd_o, wr_o, fifo_o;

    always #10 clk = ~clk;   // 50 MHz

    tf_addr_decoder uut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .addr_i(addr_i),
        .ce1_n_i(ce1_n_i), .ce2_n_i(ce2_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i),
        .iord_n_i(iord_n_i), .iowr_n_i(iowr_n_i), .attr_n_i(attr_n_i),
        .sel_o(sel_o), .rd_o(rd_o), .wr_o(wr_o), .fifo_o(fifo_o)
    );

    // control = {ce1_n, ce2_n, oe_n, we_n, iord_n, iowr_n, attr_n}
    localparam logic [6:0] C_IDLE  = 7'b0111111;
    localparam logic [6:0] C_MRD   = 7'b0101111;
    localparam logic [6:0] C_MWR   = 7'b0110111;
    localparam logic [6:0] C_MATT  = 7'b0101110;
    localparam logic [6:0] C_IRD   = 7'b0111011;
    localparam logic [6:0] C_IWR   = 7'b0111101;
    localparam logic [6:0] C_IBOTH = 7'b0111001;
    localparam logic [6:0] C_E2RD  = 7'b1011011;
    localparam logic [6:0] C_E2WR  = 7'b1011101;
    localparam logic [6:0] C_NOCE  = 7'b1111011;
    localparam logic [6:0] C_BOTHE = 7'b0011011;

    localparam logic [14:0] S_NONE = 15'h0000, S_DATA = 15'h0001, S_ERR = 15'h0002,
                            S_FEAT = 15'h0004, S_SECNUM = 15'h0010, S_CYLHI = 15'h0040,
                            S_DRVHD = 15'h0080, S_STAT = 15'h0100, S_CMD = 15'h0200,
                            S_ALT = 15'h0400, S_DEVC = 15'h0800, S_DADDR = 15'h1000,
                            S_DUPE = 15'h2000, S_DUPO = 15'h4000;

    localparam int NV = 32;
    // {req, mode, addr, control, sel, rd, wr, fifo}
    localparam logic [42:0] VEC [NV] = '{
        {4'd3,  3'd0, 11'h000, C_MRD,   S_DATA,  3'b100},  // R3 memory offset 0
        {4'd9,  3'd0, 11'h007, C_MRD,   S_STAT,  3'b100},  // R9 status read
        {4'd9,  3'd0, 11'h007, C_MWR,   S_CMD,   3'b010},  // R9 command write
        {4'd3,  3'd0, 11'h00D, C_MWR,   S_FEAT,  3'b010},  // R3 duplicate feature
        {4'd4,  3'd0, 11'h408, C_MRD,   S_DATA,  3'b101},  // R4 window read
        {4'd4,  3'd0, 11'h7FF, C_MWR,   S_DATA,  3'b011},  // R4 window write
        {4'd4,  3'd0, 11'h010, C_MRD,   S_NONE,  3'b000},  // R4 gap
        {4'd4,  3'd0, 11'h3FF, C_MRD,   S_NONE,  3'b000},  // R4 gap top
        {4'd3,  3'd0, 11'h000, C_MATT,  S_NONE,  3'b000},  // R3 attribute ignored
        {4'd10, 3'd0, 11'h001, C_IRD,   S_NONE,  3'b000},  // R10 wrong strobes
        {4'd5,  3'd1, 11'h1F0, C_IRD,   S_DATA,  3'b100},  // R5 primary data
        {4'd5,  3'd1, 11'h5F3, C_IWR,   S_SECNUM,3'b010},  // R5 A10 ignored
        {4'd9,  3'd1, 11'h3F6, C_IWR,   S_DEVC,  3'b010},  // R9 device control
        {4'd5,  3'd1, 11'h3F7, C_IRD,   S_DADDR, 3'b100},  // R5 drive address
        {4'd5,  3'd1, 11'h170, C_IRD,   S_NONE,  3'b000},  // R5 other range
        {4'd6,  3'd2, 11'h176, C_IRD,   S_DRVHD, 3'b100},  // R6 drive/head
        {4'd6,  3'd2, 11'h376, C_IRD,   S_ALT,   3'b100},  // R6 alternate status
        {4'd6,  3'd2, 11'h1F7, C_IRD,   S_NONE,  3'b000},  // R6 other range
        {4'd7,  3'd3, 11'h7F8, C_IRD,   S_DUPE,  3'b100},  // R7 high bits ignored
        {4'd7,  3'd3, 11'h009, C_IWR,   S_DUPO,  3'b010},  // R7 duplicate odd
        {4'd7,  3'd3, 11'h00D, C_IRD,   S_ERR,   3'b100},  // R7 duplicate error
        {4'd7,  3'd3, 11'h00B, C_IRD,   S_NONE,  3'b000},  // R7 hole
        {4'd10, 3'd3, 11'h001, C_MRD,   S_NONE,  3'b000},  // R10 memory strobes in I/O mode
        {4'd8,  3'd4, 11'h3F5, C_IRD,   S_CYLHI, 3'b100},  // R8 enable 1 block
        {4'd8,  3'd4, 11'h006, C_E2RD,  S_ALT,   3'b100},  // R8 enable 2 offset 6
        {4'd8,  3'd4, 11'h007, C_E2WR,  S_DADDR, 3'b010},  // R8 enable 2 offset 7
        {4'd8,  3'd4, 11'h002, C_E2RD,  S_NONE,  3'b000},  // R8 enable 2 hole
        {4'd8,  3'd4, 11'h001, C_BOTHE, S_NONE,  3'b000},  // R8 both enables
        {4'd9,  3'd4, 11'h001, C_IWR,   S_FEAT,  3'b010},  // R9 feature write
        {4'd10, 3'd1, 11'h1F1, C_IBOTH, S_NONE,  3'b000},  // R10 both strobes
        {4'd11, 3'd5, 11'h1F0, C_IRD,   S_NONE,  3'b000},  // R11 bad mode
        {4'd11, 3'd3, 11'h000, C_NOCE,  S_NONE,  3'b000}   // R11 no card enable
    };

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    task automatic drive(input logic [2:0] m, input logic [10:0] a, input logic [6:0] c);
        mode_i = m;
        addr_i = a;
        {ce1_n_i, ce2_n_i, oe_n_i, we_n_i, iord_n_i, iowr_n_i, attr_n_i} = c;
    endtask

    task automatic check(input string req, input logic [14:0] es,
                         input logic er, input logic ew, input logic ef);
        n_checks++;
        if (sel_o !== es || rd_o !== er || wr_o !== ew || fifo_o !== ef) begin
            n_fail++;
            $display("FAIL %s: got sel=%h rd=%b wr=%b fifo=%b, expected sel=%h rd=%b wr=%b fifo=%b",
                     req, sel_o, rd_o, wr_o, fifo_o, es, er, ew, ef);
        end
    endtask

    initial begin
        // R1: reset holds outputs clear even with a valid access driven
        drive(3'd1, 11'h1F0, C_IRD);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", S_NONE, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        drive(3'd0, 11'h000, C_IDLE);
        @(posedge clk);
        @(negedge clk);
        check("R10 idle", S_NONE, 1'b0, 1'b0, 1'b0);

        // R2: one register stage, nothing changes before the edge
        drive(3'd1, 11'h1F7, C_IRD);
        #1;
        check("R2 before edge", S_NONE, 1'b0, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R2 after edge", S_STAT, 1'b1, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [42:0] v;
            v = VEC[i];
            drive(v[38:36], v[35:25], v[24:18]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", v[42:39], i), v[17:3], v[2], v[1], v[0]);
        end

        // R1: reset in the middle of a window access
        drive(3'd0, 11'h400, C_MRD);
        @(posedge clk);
        @(negedge clk);
        check("R4 window before reset", S_DATA, 1'b1, 1'b0, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run", S_NONE, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        drive(3'd2, 11'h577, C_IWR);   // R6 with A10 set: command
        @(posedge clk);
        @(negedge clk);
        check("R6 A10 ignored", S_CMD, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule